// File: doc/BRIEF.md
# Gated programmable clock divider

The block derives a slower clock from its input clock. Software picks the division ratio by writing a divisor code into a small register file over a single-cycle synchronous bus (address, write strobe, write data, combinational read data). A separate enable register lets software pass the divided clock to the output or hold the output low. A status register shows a busy flag while a new divisor is waiting to take effect.

A divisor write lands in a shadow register first. The running ratio changes only when the current output period ends, which is also the next rising edge of the divided output, so a ratio change never shortens or stretches a pulse. The enable bit acts on the output only while the divided clock is low, so gating never produces a runt pulse. A parameter widens the divisor field from five to six bits. In the wide variant, the top bit of the field turns on a fixed divide-by-64 prescale of the lower five bits.

Top module: `gated_clk_divider`

## Requirements
- R1: With the 5-bit field (WIDE_DIV=0), a non-zero code N gives ratio N, so code 1 means divide by 1. Code 0 gives ratio 32.
- R2: With the 6-bit field (WIDE_DIV=1), a code with bit 5 clear gives the ratio in bits 4:0, and 0 there means 64. A code with bit 5 set gives 64 times bits 4:0, and 0x20 also gives 64.
- R3: For a ratio N of 2 or more, each output period starts with a rising edge, stays high for floor(N/2) input cycles and stays low for the rest. For ratio 1 the output follows the input clock.
- R4: Register map. Address 0 holds the divisor code in the low field bits and reads back the last code written. Address 1 holds the enable in bit 0 and reads back its state. Address 2 is status: 0x18 (bits 4 and 3) while busy, otherwise 0. Address 3 reads 0. Writes to addresses 2 and 3 change nothing.
- R5: With enable set the divided clock reaches the output, and with it clear the output is held low. A change of enable takes hold only while the divided clock is low, so a high phase already under way completes in full.
- R6: Busy reads 1 from the cycle after a divisor write until the new ratio takes effect.
- R7: A pending divisor takes effect at the end of the current output period. Busy clears on the same input edge.
- R8: A divisor write while busy replaces the pending code and leaves the running period untouched. A write in the very cycle that ends the period lets the earlier pending code take effect, keeps the new code pending and keeps busy set.
- R9: Reset clears enable, loads divisor code 1, clears busy and holds the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided; also clocks the registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for addr_i, combinational |
| div_clk_o | output | 1 | Gated divided clock |

## Verification
A divisor write and the end of an output period can fall in the same input cycle. When that happens, the shadow register is being loaded at the very edge where it is copied into the running ratio. The bench measures a known ratio from a rising edge and then places a second write exactly on the cycle that closes the period. It then checks three things: the earlier pending code sets the next period's high and low lengths, the later code sets the period after that, and busy stays set between the two. Separately, an enable change that arrives while the divided clock is high is checked for letting the high phase finish at full length.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Largest ratio is 64 * 31 = 1984, which fits in 11 bits
  localparam int RATIO_W = 11;
  // Status bits that carry the busy flag (decoded by software as 0x18)
  localparam int STAT_BUSY_LO = 3;
  localparam int STAT_BUSY_HI = 4;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_EN   = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Map a divisor code onto the division ratio
  function automatic ratio_t decode_ratio(input logic [5:0] code, input bit wide);
    ratio_t r;
    if (wide && code[5]) r = ratio_t'({code[4:0], 6'b000000});
    else                 r = ratio_t'(code[4:0]);
    if (r == '0) r = wide ? ratio_t'(64) : ratio_t'(32);
    return r;
  endfunction

endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs #(
  parameter int DIV_W  = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              switch_i,
  output logic [DIV_W-1:0]  pend_code_o,
  output logic              busy_o,
  output logic              en_o,
  output logic [DATA_W-1:0] rd_data_o
);
  import cdiv_pkg::*;

  logic     in_range;
  reg_sel_e sel;
  logic     div_wr, en_wr;

  assign in_range = ((addr_i >> 2) == '0);
  assign sel      = in_range ? reg_sel_e'(addr_i[1:0]) : REG_NONE;
  assign div_wr   = wr_en_i && (sel == REG_DIV);
  assign en_wr    = wr_en_i && (sel == REG_EN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_code_o <= DIV_W'(1);
      busy_o      <= 1'b0;
      en_o        <= 1'b0;
    end else begin
      if (div_wr) pend_code_o <= wr_data_i[DIV_W-1:0];
      if (en_wr)  en_o        <= wr_data_i[0];
      // a fresh write keeps busy set even in the cycle the old code is applied
      if (div_wr)        busy_o <= 1'b1;
      else if (switch_i) busy_o <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (sel)
      REG_DIV:  rd_data_o[DIV_W-1:0] = pend_code_o;
      REG_EN:   rd_data_o[0] = en_o;
      REG_STAT: rd_data_o[STAT_BUSY_HI:STAT_BUSY_LO] = {2{busy_o}};
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
  parameter int DIV_W = 5,
  parameter bit WIDE  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] pend_code_i,
  input  logic             busy_i,
  output logic             switch_o,
  output logic             div_o,
  output logic             pass_o,
  output logic [DIV_W-1:0] act_code_o
);
  import cdiv_pkg::*;

  ratio_t cnt_q, ratio, pend_ratio, nxt_ratio, nxt_cnt;
  logic   period_end;

  assign ratio      = decode_ratio(6'(act_code_o), WIDE);
  assign pend_ratio = decode_ratio(6'(pend_code_i), WIDE);
  assign period_end = (cnt_q == ratio - ratio_t'(1));
  assign switch_o   = period_end && busy_i;
  assign nxt_ratio  = switch_o ? pend_ratio : ratio;
  assign nxt_cnt    = period_end ? '0 : cnt_q + ratio_t'(1);
  assign pass_o     = (ratio == ratio_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_code_o <= DIV_W'(1);
      cnt_q      <= '0;
      div_o      <= 1'b0;
    end else begin
      if (switch_o) act_code_o <= pend_code_i;
      cnt_q <= nxt_cnt;
      // high for the first floor(N/2) cycles of each period
      div_o <= (nxt_cnt < (nxt_ratio >> 1));
    end
  end

endmodule

// File: rtl/cdiv_gate.sv
module cdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div_i,
  input  logic pass_i,
  output logic gate_o,
  output logic clk_o
);
  logic gate_n_q;

  // gate follows the enable only while the divided clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gate_o <= 1'b0;
    else if (!div_i) gate_o <= en_i;
  end

  // copy for the pass-through path, changed while the input clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_n_q <= 1'b0;
    else         gate_n_q <= gate_o;
  end

  assign clk_o = pass_i ? (clk_i & gate_n_q) : (div_i & gate_o);

endmodule

// File: rtl/gated_clk_divider.sv
module gated_clk_divider #(
  parameter bit WIDE_DIV = 1'b0,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              div_clk_o
);
  localparam int DIV_W = WIDE_DIV ? 6 : 5;

  logic [DIV_W-1:0] pend_code, act_code;
  logic busy, en, switch_now, div_q, pass, gate_q;

  cdiv_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .switch_i    (switch_now),
    .pend_code_o (pend_code),
    .busy_o      (busy),
    .en_o        (en),
    .rd_data_o   (rd_data_o)
  );

  cdiv_counter #(.DIV_W(DIV_W), .WIDE(WIDE_DIV)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_code_i (pend_code),
    .busy_i      (busy),
    .switch_o    (switch_now),
    .div_o       (div_q),
    .pass_o      (pass),
    .act_code_o  (act_code)
  );

  cdiv_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .div_i  (div_q),
    .pass_i (pass),
    .gate_o (gate_q),
    .clk_o  (div_clk_o)
  );

endmodule

// File: rtl/gated_clk_divider_chk.sv
module gated_clk_divider_chk #(
  parameter int ADDR_W = 2,
  parameter int DIV_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_i,
  input logic              gate_i,
  input logic              div_i,
  input logic [DIV_W-1:0]  act_i,
  input logic [DIV_W-1:0]  pend_i
);

  // R6
  div_write_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0) |=> busy_i);

  // R5
  gate_when_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_i) |-> !$past(div_i));

  // R7
  switch_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_i) |-> $past(busy_i));

  // R7
  busy_clear_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (act_i == $past(pend_i)));

endmodule

bind gated_clk_divider gated_clk_divider_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .busy_i  (busy),
  .gate_i  (gate_q),
  .div_i   (div_q),
  .act_i   (act_code),
  .pend_i  (pend_code)
);

// File: tb/gated_clk_divider_tb_top.sv
module gated_clk_divider_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       wr_n = 1'b0, wr_w = 1'b0;
  logic [7:0] rd_n, rd_w;
  logic       out_n, out_w;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  gated_clk_divider dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_n),
    .wr_data_i(wdata), .rd_data_o(rd_n), .div_clk_o(out_n));

  gated_clk_divider #(.WIDE_DIV(1'b1)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_w),
    .wr_data_i(wdata), .rd_data_o(rd_w), .div_clk_o(out_w));

  function automatic int exp_ratio(bit wide, int code);
    int r;
    if (wide && code[5]) r = 64 * (code & 31);
    else                 r = code & 31;
    if (r == 0) r = wide ? 64 : 32;
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic outv(bit sel);
    return sel ? out_w : out_n;
  endfunction

  task automatic wr(bit sel, int a, int d);
    addr = 2'(a); wdata = 8'(d);
    if (sel) wr_w = 1'b1; else wr_n = 1'b1;
    @(posedge clk); #1;
    wr_w = 1'b0; wr_n = 1'b0;
  endtask

  task automatic rd(bit sel, int a, output int v);
    addr = 2'(a); #1;
    v = sel ? int'(rd_w) : int'(rd_n);
  endtask

  task automatic wait_idle(bit sel);
    int v;
    for (int i = 0; i < 10000; i++) begin
      rd(sel, 2, v);
      if (v == 0) return;
      tick();
    end
  endtask

  task automatic find_rise(bit sel);
    logic prev;
    prev = outv(sel);
    for (int i = 0; i < 10000; i++) begin
      tick();
      if (!prev && outv(sel)) return;
      prev = outv(sel);
    end
  endtask

  // current sample is high and pre_h highs of this period are counted
  task automatic count_from_rise(bit sel, int pre_h, output int h, output int l);
    h = pre_h; l = 0;
    for (int i = 0; i < 10000; i++) begin
      tick();
      if (outv(sel)) h++; else break;
    end
    l = 1;
    for (int i = 0; i < 10000; i++) begin
      tick();
      if (!outv(sel)) l++; else break;
    end
  endtask

  task automatic measure_check(bit sel, int code, string tag);
    int h, l, n;
    n = exp_ratio(sel, code);
    find_rise(sel);
    count_from_rise(sel, 1, h, l);
    check(h == n / 2, {tag, " high"}, h, n / 2);
    check(l == n - n / 2, {tag, " low"}, l, n - n / 2);
  endtask

  task automatic pass_check(bit sel, string tag);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check(outv(sel) == 1'b1, {tag, " pass high"}, int'(outv(sel)), 1);
      @(negedge clk); #2;
      check(outv(sel) == 1'b0, {tag, " pass low"}, int'(outv(sel)), 0);
    end
  endtask

  task automatic set_div(bit sel, int code);
    wait_idle(sel);
    wr(sel, 0, code);
    wait_idle(sel);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int v, h, l, code;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(out_n == 1'b0, "R9 output low in reset", int'(out_n), 0);
    rst_n = 1'b1;
    tick();
    rd(0, 0, v); check(v == 1, "R9 reset divisor code", v, 1);
    rd(0, 1, v); check(v == 0, "R9 reset enable", v, 0);
    rd(0, 2, v); check(v == 0, "R9 reset busy", v, 0);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #2;
      check(out_n == 1'b0, "R9 output low while disabled", int'(out_n), 0);
    end
    tick();

    // R4 enable readback, R3 ratio-1 pass-through
    wr(0, 1, 1);
    rd(0, 1, v); check(v == 1, "R4 enable readback", v, 1);
    wr(1, 1, 1);
    repeat (3) tick();
    pass_check(0, "R3 narrow");
    pass_check(1, "R3 wide");
    tick();

    // R1 code 0 gives 32, odd and even ratios
    set_div(0, 0);  measure_check(0, 0, "R1 code0");
    set_div(0, 3);  measure_check(0, 3, "R3 odd ratio");
    set_div(0, 2);  measure_check(0, 2, "R3 even ratio");

    // R4 unused addresses
    wr(0, 2, 8'hFF); wr(0, 3, 8'hFF);
    rd(0, 3, v); check(v == 0, "R4 addr3 reads zero", v, 0);
    rd(0, 2, v); check(v == 0, "R4 status write ignored", v, 0);
    rd(0, 0, v); check(v == 2, "R4 divisor unchanged by other writes", v, 2);

    // random codes, R1/R3/R4/R6
    for (int it = 0; it < 20; it++) begin
      code = int'($urandom % 32);
      wait_idle(0);
      wr(0, 0, code);
      rd(0, 2, v); check(v == 8'h18, "R6 busy after write", v, 8'h18);
      rd(0, 0, v); check(v == code, "R4 divisor readback", v, code);
      wait_idle(0);
      if (code == 1) begin
        repeat (2) tick();
        pass_check(0, "R1 code1 pass");
      end else measure_check(0, code, "R1 random");
    end

    // R8 replacement while busy
    set_div(0, 20);
    find_rise(0);
    wr(0, 0, 5);
    wr(0, 0, 7);
    check(out_n == 1'b1, "R8 running period kept", int'(out_n), 1);
    count_from_rise(0, 3, h, l);
    check(h == 10 && l == 10, "R8 running period length", h + l, 20);
    count_from_rise(0, 1, h, l);
    check(h == 3 && l == 4, "R8 replaced code applied", h + l, 7);
    rd(0, 2, v); check(v == 0, "R7 busy cleared after switch", v, 0);

    // R8 write in the period-closing cycle
    set_div(0, 6);
    find_rise(0);
    wr(0, 0, 9);
    repeat (4) tick();
    wr(0, 0, 4);
    check(out_n == 1'b1, "R7 new period starts on switch edge", int'(out_n), 1);
    rd(0, 2, v); check(v == 8'h18, "R8 busy kept on collision", v, 8'h18);
    count_from_rise(0, 1, h, l);
    check(h == 4 && l == 5, "R8 earlier code applied first", h + l, 9);
    count_from_rise(0, 1, h, l);
    check(h == 2 && l == 2, "R8 later code applied next", h + l, 4);

    // R5 disable during high phase
    set_div(0, 10);
    find_rise(0);
    wr(0, 1, 0);
    check(out_n == 1'b1, "R5 high phase continues", int'(out_n), 1);
    h = 2;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (out_n) h++; else break;
    end
    check(h == 5, "R5 full high before gating", h, 5);
    v = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (out_n) v++;
    end
    check(v == 0, "R5 output held low when disabled", v, 0);
    rd(0, 1, v); check(v == 0, "R4 enable clear readback", v, 0);
    // enable written at an arbitrary phase
    find_rise(0);
    wr(0, 1, 1);
    measure_check(0, 10, "R5 re-enable full pulse");

    // R2 wide field
    set_div(1, 0);     measure_check(1, 0, "R2 wide code0");
    set_div(1, 8'h20); measure_check(1, 8'h20, "R2 wide 0x20");
    set_div(1, 8'h22); measure_check(1, 8'h22, "R2 wide 0x22");
    set_div(1, 8'h25); measure_check(1, 8'h25, "R2 wide 0x25");
    set_div(1, 8'h1F); measure_check(1, 8'h1F, "R2 wide 0x1F");
    set_div(1, 8'h3F); measure_check(1, 8'h3F, "R2 wide 0x3F");
    rd(1, 0, v); check(v == 8'h3F, "R2 wide readback", v, 8'h3F);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule